// File: doc/BRIEF.md
# Shutter Speed Setting Interface

This block turns the settings on three shared camera control lines into an 8-bit exposure load value for a CCD timing generator. The load value tells the timing generator how many lines of charge discharge come before readout, so a smaller value gives a shorter exposure. A mode input decides what the three lines mean. In parallel mode they form a 3-bit preset code that picks one of eight fixed shutter speeds. In serial mode they are a data line, a shift clock and an apply strobe. Bits are shifted into a staging register, and the staged word becomes the active value only when the strobe rises.

A standard-select input picks which preset table parallel mode uses: one for 525-line (EIA) timing or one for 625-line (CCIR) timing. An enable input and an iris-mode input decide whether the shutter setting is in force. While the shutter function is not in force, the block ignores all activity on the three lines. It synchronises every line to its own clock and detects edges after synchronisation, so the lines may be driven from slow external logic.

Top module: `shutter_speed_if`

## Requirements
- R1: After reset, load_val_o is 00h and the staging register is clear. A strobe in serial mode with no bits shifted therefore yields 00h.
- R2: In parallel mode with ccir_i low, the code {line2_i,line1_i,line0_i} selects these values: 7 gives EDh, 6 gives CAh, 5 gives ACh, 4 gives 9Ch, 3 gives 87h, 2 gives 6Ah, 1 gives 4Eh and 0 gives 00h.
- R3: In parallel mode with ccir_i high, the same codes select these values: 7 gives E1h, 6 gives C5h, 5 gives A7h, 4 gives 97h, 3 gives 82h, 2 gives 65h, 1 gives 4Ah and 0 gives 00h.
- R4: In parallel mode, load_val_o shows the new preset no later than the third rising clock edge after the code lines or ccir_i change.
- R5: In serial mode, each rising edge on line1_i (the shift clock) shifts the level on line2_i (the data) into the staging register. The first bit shifted ends up as bit 7 of the applied word, so words go in most significant bit first.
- R6: In serial mode, load_val_o changes only on a rising edge of line0_i (the strobe). It then takes the staging register content, and ccir_i has no effect on it.
- R7: While enable_i is low or iris_mode_i is high, the block ignores edges and levels on the three lines. load_val_o holds its value and the staging register keeps its content.
- R8: shutter_on_o is high exactly when enable_i is high and iris_mode_i is low. discharge_en_o follows enable_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Discharge pulse enable; low stops discharge |
| iris_mode_i | input | 1 | High selects iris mode, low selects shutter mode |
| serial_mode_i | input | 1 | High selects serial loading, low selects parallel presets |
| ccir_i | input | 1 | Standard select: low for EIA, high for CCIR |
| line0_i | input | 1 | Strobe (serial) or code bit 0 (parallel) |
| line1_i | input | 1 | Shift clock (serial) or code bit 1 (parallel) |
| line2_i | input | 1 | Data (serial) or code bit 2 (parallel) |
| load_val_o | output | 8 | Active exposure load value |
| shutter_on_o | output | 1 | Shutter setting is in force |
| discharge_en_o | output | 1 | Discharge pulse output enabled |

## Verification
The hardest case to reach from the ports is showing that the staging register was left alone while the shutter was out of force. That register has no port of its own. To reach it, the bench first stages a known word in serial mode. It then clocks a different pattern through the lines while iris mode is on and again while enable is low. After shutter mode returns, it raises the strobe with no new bits shifted. The applied value must equal the earlier word, and load_val_o must not have moved during the blocked activity.

// File: rtl/shutter_pkg.sv
package shutter_pkg;
  localparam int WORD_W = 8;
  localparam int CODE_W = 3;
  localparam int N_CODES = 1 << CODE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic {STD_EIA = 1'b0, STD_CCIR = 1'b1} std_e;

  // Code 7 is the longest exposure, code 0 the shortest.
  function automatic word_t preset_val(std_e s, code_t c);
    word_t v;
    if (s == STD_CCIR) begin
      case (c)
        3'd7:    v = 8'hE1;
        3'd6:    v = 8'hC5;
        3'd5:    v = 8'hA7;
        3'd4:    v = 8'h97;
        3'd3:    v = 8'h82;
        3'd2:    v = 8'h65;
        3'd1:    v = 8'h4A;
        default: v = 8'h00;
      endcase
    end else begin
      case (c)
        3'd7:    v = 8'hED;
        3'd6:    v = 8'hCA;
        3'd5:    v = 8'hAC;
        3'd4:    v = 8'h9C;
        3'd3:    v = 8'h87;
        3'd2:    v = 8'h6A;
        3'd1:    v = 8'h4E;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg[0] <= '0;
          else         stg[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg[s] <= '0;
          else         stg[s] <= stg[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg[STAGES-1];

  assign q_o    = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/serial_stager.sv
module serial_stager
  import shutter_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  shift_i,
  input  logic  bit_i,
  output word_t stage_o
);
  word_t sr_q;

  // MSB first: earliest bit migrates to the top
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};

  assign stage_o = sr_q;
endmodule

// File: rtl/preset_lookup.sv
module preset_lookup
  import shutter_pkg::*;
(
  input  std_e  std_i,
  input  code_t code_i,
  output word_t val_o
);
  word_t tbl [2];

  generate
    for (genvar g = 0; g < 2; g++) begin : g_std
      assign tbl[g] = preset_val(std_e'(g), code_i);
    end
  endgenerate

  assign val_o = tbl[std_i];
endmodule

// File: rtl/shutter_speed_if.sv
module shutter_speed_if
  import shutter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              iris_mode_i,
  input  logic              serial_mode_i,
  input  logic              ccir_i,
  input  logic              line0_i,
  input  logic              line1_i,
  input  logic              line2_i,
  output logic [WORD_W-1:0] load_val_o,
  output logic              shutter_on_o,
  output logic              discharge_en_o
);
  logic [CODE_W-1:0] lines_sync, lines_rise;
  logic              strobe_rise, shift_rise, data_bit, shift_en, active;
  word_t             stage_w, preset_w, active_q;

  pin_sync #(.W(CODE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({line2_i, line1_i, line0_i}),
    .q_o    (lines_sync),
    .rise_o (lines_rise)
  );

  assign strobe_rise = lines_rise[0];
  assign shift_rise  = lines_rise[1];
  assign data_bit    = lines_sync[2];
  assign active      = enable_i & ~iris_mode_i;
  assign shift_en    = active & serial_mode_i & shift_rise;

  serial_stager u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_en),
    .bit_i   (data_bit),
    .stage_o (stage_w)
  );

  preset_lookup u_lut (
    .std_i  (std_e'(ccir_i)),
    .code_i (lines_sync),
    .val_o  (preset_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                            active_q <= '0;
    else if (active && !serial_mode_i)      active_q <= preset_w;
    else if (active && strobe_rise)         active_q <= stage_w;

  assign load_val_o     = active_q;
  assign shutter_on_o   = active;
  assign discharge_en_o = enable_i;
endmodule

// File: rtl/shutter_speed_if_chk.sv
module shutter_speed_if_chk
  import shutter_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        serial_mode_i,
  input logic        ccir_i,
  input logic        shutter_on_o,
  input logic [7:0]  load_val_o,
  input logic        strobe_rise,
  input logic        shift_en,
  input logic        data_bit,
  input logic [2:0]  lines_sync,
  input word_t       stage_w
);
  // R7
  inactive_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shutter_on_o |=> $stable(load_val_o));

  // R6
  serial_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serial_mode_i && !strobe_rise) |=> $stable(load_val_o));

  // R6
  serial_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serial_mode_i && shutter_on_o && strobe_rise) |=> load_val_o == $past(stage_w));

  // R5
  shift_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> stage_w == {$past(stage_w[6:0]), $past(data_bit)});

  // R2
  eia_slowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!serial_mode_i && shutter_on_o && !ccir_i && lines_sync == 3'd7) |=> load_val_o == 8'hED);

  // R3
  ccir_slowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!serial_mode_i && shutter_on_o && ccir_i && lines_sync == 3'd7) |=> load_val_o == 8'hE1);
endmodule

bind shutter_speed_if shutter_speed_if_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .serial_mode_i (serial_mode_i),
  .ccir_i        (ccir_i),
  .shutter_on_o  (shutter_on_o),
  .load_val_o    (load_val_o),
  .strobe_rise   (strobe_rise),
  .shift_en      (shift_en),
  .data_bit      (data_bit),
  .lines_sync    (lines_sync),
  .stage_w       (stage_w)
);

// File: tb/shutter_speed_if_bench.sv
`timescale 1ns/1ps
module shutter_speed_if_bench;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       enable_i = 1'b1, iris_mode_i = 1'b0, serial_mode_i = 1'b0, ccir_i = 1'b0;
  logic       line0_i = 1'b0, line1_i = 1'b0, line2_i = 1'b0;
  logic [7:0] load_val_o;
  logic       shutter_on_o, discharge_en_o;
  int         n_chk = 0, n_fail = 0, cyc = 0;

  logic [7:0] eia_t  [8] = '{8'h00, 8'h4E, 8'h6A, 8'h87, 8'h9C, 8'hAC, 8'hCA, 8'hED};
  logic [7:0] ccir_t [8] = '{8'h00, 8'h4A, 8'h65, 8'h82, 8'h97, 8'hA7, 8'hC5, 8'hE1};

  always #10 clk_i = ~clk_i;

  shutter_speed_if u_shutter_speed_if (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_code(logic [2:0] c);
    {line2_i, line1_i, line0_i} = c;
    wait_n(4);
  endtask

  task automatic shift_word(logic [7:0] w);
    for (int i = 7; i >= 0; i--) begin
      line2_i = w[i];
      line1_i = 1'b0;
      wait_n(3);
      line1_i = 1'b1;
      wait_n(4);
    end
    line1_i = 1'b0;
    wait_n(3);
  endtask

  task automatic strobe();
    line0_i = 1'b1;
    wait_n(4);
    line0_i = 1'b0;
    wait_n(3);
  endtask

  task automatic t_reset();
    chk("R1 reset value", load_val_o, 8'h00);
    serial_mode_i = 1'b1;
    wait_n(2);
    strobe();
    chk("R1 cleared stage", load_val_o, 8'h00);
    serial_mode_i = 1'b0;
  endtask

  task automatic t_parallel();
    ccir_i = 1'b0;
    for (int c = 0; c < 8; c++) begin
      set_code(3'(c));
      chk("R2 eia preset", load_val_o, eia_t[c]);
    end
    ccir_i = 1'b1;
    for (int c = 7; c >= 0; c--) begin
      set_code(3'(c));
      chk("R3 ccir preset", load_val_o, ccir_t[c]);
    end
  endtask

  task automatic t_latency();
    ccir_i = 1'b0;
    set_code(3'd1);
    {line2_i, line1_i, line0_i} = 3'd6;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R4 not yet through sync", load_val_o, 8'h4E);
    @(negedge clk_i);
    chk("R4 third edge", load_val_o, 8'hCA);
    ccir_i = 1'b1;
    wait_n(3);
    chk("R4 standard switch", load_val_o, 8'hC5);
    set_code(3'd0);
    ccir_i = 1'b0;
  endtask

  task automatic t_serial();
    serial_mode_i = 1'b1;
    ccir_i = 1'b0;
    wait_n(2);
    shift_word(8'hA6);
    chk("R6 no change before strobe", load_val_o, 8'h00);
    strobe();
    chk("R5 msb first word", load_val_o, 8'hA6);
    ccir_i = 1'b1;
    shift_word(8'h3C);
    chk("R6 held while shifting", load_val_o, 8'hA6);
    strobe();
    chk("R6 applied, standard ignored", load_val_o, 8'h3C);
    ccir_i = 1'b0;
  endtask

  task automatic t_gating();
    iris_mode_i = 1'b1;
    wait_n(1);
    chk("R8 shutter off in iris", {7'd0, shutter_on_o}, 8'h01 & 8'h00);
    shift_word(8'hFF);
    strobe();
    chk("R7 iris ignores lines", load_val_o, 8'h3C);
    iris_mode_i = 1'b0;
    enable_i = 1'b0;
    wait_n(1);
    chk("R8 discharge off", {6'd0, discharge_en_o, shutter_on_o}, 8'h00);
    shift_word(8'h81);
    strobe();
    chk("R7 disabled ignores lines", load_val_o, 8'h3C);
    enable_i = 1'b1;
    wait_n(1);
    chk("R8 enabled shutter", {6'd0, discharge_en_o, shutter_on_o}, 8'h03);
    strobe();
    chk("R7 stage kept", load_val_o, 8'h3C);
    serial_mode_i = 1'b0;
    iris_mode_i = 1'b1;
    set_code(3'd7);
    chk("R7 parallel ignored in iris", load_val_o, 8'h3C);
    iris_mode_i = 1'b0;
    wait_n(2);
    chk("R2 resumes preset", load_val_o, 8'hED);
  endtask

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(2);
    t_reset();
    t_parallel();
    t_latency();
    t_serial();
    t_gating();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule